// File: doc/BRIEF.md
# Primary-Side Rectifier Trigger Pulse Generator

This block sits beside the pulse-width modulator of an isolated forward converter. It turns one PWM command into three timed outputs. The first is a delayed copy of the PWM that drives the primary switches. The other two are short trigger pulses sent across the isolation barrier. One trigger pulse, `xn`, tells the secondary rectifier drivers to switch off. The other, `xp`, tells them to switch on. The primary command is delayed more on its leading edge than on its trailing edge. This lets the turn-off pulse reach the secondary before the primary switches change state.

The turn-on pulse has two possible sources. One is the leading edge of the delayed primary command, with an adjustable dead time. The other is a falling edge on the winding-detect input, which marks the start of freewheeling. The two pulses are interlocked so that they are never high together. A duty-cycle monitor suppresses the turn-on pulse when the PWM runs at light load. All timing is counted in clock cycles, with 10 ns per cycle assumed.

Top module: `srt_trigger_gen`

## Requirements
- R1: While `rst_n` is low, `sout`, `xn` and `xp` are low. After reset, `xp` stays inhibited until one full PWM period (rising edge to rising edge) has been measured and has passed the duty test.
- R2: Both inputs pass through two synchronizer flops. Let edge 0 be the first clock edge that samples a changed `pwm_in`. `sout` rises at edge 32 for a rising change and falls at edge 12 for a falling change. An input level that does not last long enough for this never reaches `sout`.
- R3: Every rising and every falling PWM edge makes `xn` rise at edge 7, counted the same way as in R2. `xn` then stays high for exactly 30 cycles.
- R4: A new PWM edge that arrives while an `xn` pulse is pending or high restarts that pulse. `xn` drops at the edge that accepts the new trigger, then rises 5 cycles later and lasts 30 cycles.
- R5: When `xn` is caused by a PWM falling edge, it is already high when `sout` falls.
- R6: A rising `sout` requests `xp`. If `xn` is low, `xp` rises `dly_adj + 2` cycles after `sout` rises, where `dly_adj` is an unsigned 4-bit count from 0 to 15. Every `xp` pulse lasts at most 70 cycles, and exactly 70 cycles when nothing cuts it short.
- R7: A falling edge on `det_in` requests `xp`. If `xn` is low, `xp` rises at edge 7 after the edge that samples the change, counted as in R2.
- R8: A request that becomes due while `xn` is high is held. `xp` then rises one cycle after `xn` falls.
- R9: `xp` falls at the same edge where `xn` rises, so the two outputs are never high together.
- R10: At each PWM rising edge, the block measures the period P (cycles since the previous rising edge) and the high time H. `xp` is allowed for the next period only if 10·H ≥ P. If the test fails, requests are dropped, while `xn` keeps running.
- R11: If no PWM rising edge arrives within 2^CNT_W − 1 cycles, `xp` is inhibited. The first period measured after that overflow also fails the duty test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns per cycle assumed |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| det_in | input | 1 | Winding-detect comparator output, asynchronous |
| dly_adj | input | ADJ_W | Extra cycles from `sout` rising to `xp` |
| sout | output | 1 | Delayed primary switch command |
| xn | output | 1 | Rectifier turn-off trigger pulse |
| xp | output | 1 | Rectifier turn-on trigger pulse |

## Verification
Each output is fed by its own counter: the asymmetric delay counter for `sout`, the one-shot for `xn`, and the request and width counters for `xp`. A wrong count therefore shows up as an edge on the wrong cycle within tens of cycles of the PWM or detect edge that caused it. The bench compares exact edge times for each delay setting and each detect offset. A stale duty decision or a period counter that never saturates is slower to see. It shows one whole PWM period later, as an `xp` pulse that appears or goes missing. The bench sweeps the high time across the 10 % boundary to catch it.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [1:0] {
    OS_IDLE  = 2'd0,
    OS_WAIT  = 2'd1,
    OS_PULSE = 2'd2
  } os_state_e;

  // Duty test: pass when div*high >= period and the period counter never saturated.
  function automatic logic duty_pass(input logic [31:0] hi,
                                     input logic [31:0] per,
                                     input logic [31:0] div,
                                     input logic [31:0] per_max);
    return (per < per_max) && ((hi * div) >= per);
  endfunction

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srt_edge_delay.sv
// Delays a level by RISE cycles on its rising edge and FALL cycles on its
// falling edge; any input edge restarts the count, so short levels are filtered.
module srt_edge_delay #(
  parameter int RISE = 30,
  parameter int FALL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic edge_i,
  output logic dout
);
  localparam int MAXD = srt_pkg::max_i(RISE, FALL);
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;

  assign tgt = din ? CW'(RISE) : CW'(FALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (edge_i) begin
      cnt <= CW'(1);
    end else if (dout != din) begin
      if (cnt >= tgt) dout <= din;
      else            cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srt_oneshot.sv
// Retriggerable delayed one-shot: a trigger waits DLY cycles, then the
// output is high for WID cycles. A new trigger restarts the sequence.
module srt_oneshot #(
  parameter int DLY = 5,
  parameter int WID = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse,
  output logic launch
);
  import srt_pkg::*;

  localparam int CW = $clog2(max_i(DLY, WID) + 1);

  os_state_e     st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= OS_IDLE;
      cnt <= '0;
    end else if (trig) begin
      st  <= OS_WAIT;
      cnt <= CW'(DLY - 1);
    end else begin
      case (st)
        OS_WAIT: begin
          if (cnt == '0) begin
            st  <= OS_PULSE;
            cnt <= CW'(WID - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        OS_PULSE: begin
          if (cnt == '0) st  <= OS_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pulse  = (st == OS_PULSE);
  // High in the cycle before the output rises.
  assign launch = (st == OS_WAIT) && (cnt == '0) && !trig;
endmodule

// File: rtl/srt_duty_mon.sv
// Measures period and high time between PWM rising edges and decides
// whether turn-on triggers are allowed.
module srt_duty_mon #(
  parameter int CNT_W = 16,
  parameter int DIV   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_s,
  input  logic rise,
  output logic duty_ok
);
  import srt_pkg::*;

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
      seen    <= 1'b0;
      duty_ok <= 1'b0;
    end else if (rise) begin
      if (seen) duty_ok <= duty_pass(32'(hi_cnt), 32'(per_cnt), 32'(DIV), 32'(CMAX));
      seen    <= 1'b1;
      per_cnt <= CNT_W'(1);
      hi_cnt  <= CNT_W'(1);
    end else begin
      if (per_cnt != CMAX) per_cnt <= per_cnt + 1'b1;
      else                 duty_ok <= 1'b0;
      if (pwm_s && (hi_cnt != CMAX)) hi_cnt <= hi_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srt_xp_ctl.sv
// Turn-on trigger control: takes requests from SOUT rising (adjustable
// dead time) or DET falling (fixed delay), holds them while XN is busy,
// and drops them when the duty test fails.
module srt_xp_ctl #(
  parameter int XP_W    = 70,
  parameter int DET_DLY = 5,
  parameter int ADJ_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sout_rise,
  input  logic             det_fall,
  input  logic [ADJ_W-1:0] adj,
  input  logic             xn,
  input  logic             xn_launch,
  input  logic             duty_ok,
  output logic             xp,
  output logic             fire
);
  import srt_pkg::*;

  localparam int PCW = max_i(ADJ_W, $clog2(DET_DLY + 1));
  localparam int XCW = $clog2(XP_W + 1);

  logic           pend;
  logic [PCW-1:0] pcnt;
  logic [XCW-1:0] wcnt;
  logic           new_req;

  assign new_req = sout_rise || det_fall;
  assign fire    = pend && (pcnt == '0) && !xn && !xn_launch && !xp && !new_req;

  // Request holder
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pcnt <= '0;
    end else if (new_req) begin
      pend <= 1'b1;
      pcnt <= sout_rise ? PCW'(adj) : PCW'(DET_DLY - 1);
    end else if (fire) begin
      pend <= 1'b0;
    end else if (pend && (pcnt != '0)) begin
      pcnt <= pcnt - 1'b1;
    end
  end

  // Pulse width and interlock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp   <= 1'b0;
      wcnt <= '0;
    end else if (xn_launch) begin
      xp <= 1'b0;
    end else if (fire && duty_ok) begin
      xp   <= 1'b1;
      wcnt <= XCW'(XP_W - 1);
    end else if (xp) begin
      if (wcnt == '0) xp   <= 1'b0;
      else            wcnt <= wcnt - 1'b1;
    end
  end
endmodule

// File: rtl/srt_trigger_gen.sv
module srt_trigger_gen #(
  parameter int SOUT_RISE_CYC = 30,
  parameter int SOUT_FALL_CYC = 10,
  parameter int XN_DLY_CYC    = 5,
  parameter int XN_W_CYC      = 30,
  parameter int XP_W_CYC      = 70,
  parameter int DET_DLY_CYC   = 5,
  parameter int ADJ_W         = 4,
  parameter int DUTY_DIV      = 10,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             det_in,
  input  logic [ADJ_W-1:0] dly_adj,
  output logic             sout,
  output logic             xn,
  output logic             xp
);
  localparam int NSYNC = 2;

  // Two-flop synchronizers: bit 0 = PWM, bit 1 = DET
  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync1;
  logic [NSYNC-1:0] sync2;
  logic [NSYNC-1:0] sync_d;

  assign raw_in = {det_in, pwm_in};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync1[g]  <= 1'b0;
        sync2[g]  <= 1'b0;
        sync_d[g] <= 1'b0;
      end else begin
        sync1[g]  <= raw_in[g];
        sync2[g]  <= sync1[g];
        sync_d[g] <= sync2[g];
      end
    end
  end

  // Named internal events
  logic pwm_s, pwm_edge, pwm_rise, det_fall;
  logic sout_d, sout_rise;
  logic xn_launch, duty_ok, xp_fire;

  assign pwm_s    = sync2[0];
  assign pwm_edge = sync2[0] ^ sync_d[0];
  assign pwm_rise = sync2[0] & ~sync_d[0];
  assign det_fall = ~sync2[1] & sync_d[1];

  srt_edge_delay #(.RISE(SOUT_RISE_CYC), .FALL(SOUT_FALL_CYC)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(pwm_s), .edge_i(pwm_edge), .dout(sout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sout_d <= 1'b0;
    else        sout_d <= sout;
  end
  assign sout_rise = sout & ~sout_d;

  srt_oneshot #(.DLY(XN_DLY_CYC), .WID(XN_W_CYC)) u_xn (
    .clk(clk), .rst_n(rst_n), .trig(pwm_edge), .pulse(xn), .launch(xn_launch)
  );

  srt_duty_mon #(.CNT_W(CNT_W), .DIV(DUTY_DIV)) u_duty (
    .clk(clk), .rst_n(rst_n), .pwm_s(pwm_s), .rise(pwm_rise), .duty_ok(duty_ok)
  );

  srt_xp_ctl #(.XP_W(XP_W_CYC), .DET_DLY(DET_DLY_CYC), .ADJ_W(ADJ_W)) u_xp (
    .clk(clk), .rst_n(rst_n), .sout_rise(sout_rise), .det_fall(det_fall),
    .adj(dly_adj), .xn(xn), .xn_launch(xn_launch), .duty_ok(duty_ok),
    .xp(xp), .fire(xp_fire)
  );
endmodule

// File: rtl/srt_trigger_chk.sv
module srt_trigger_chk #(
  parameter int XN_W = 30,
  parameter int XP_W = 70
) (
  input logic clk,
  input logic rst_n,
  input logic sout,
  input logic xn,
  input logic xp,
  input logic pwm_s,
  input logic duty_ok
);
  logic [15:0] xn_run;
  logic [15:0] xp_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xn_run <= '0;
      xp_run <= '0;
    end else begin
      xn_run <= xn ? xn_run + 1'b1 : '0;
      xp_run <= xp ? xp_run + 1'b1 : '0;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(xn && xp)); // R9
  AST_XP_AFTER_XN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(xp) |-> !$past(xn)); // R8
  AST_XP_NEEDS_DUTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(xp) |-> $past(duty_ok)); // R10
  AST_SOUT_FALL_UNDER_XN: assert property (@(posedge clk) disable iff (!rst_n) $fell(sout) |-> xn); // R5
  AST_SOUT_TRACKS_PWM: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sout) |-> (sout == $past(pwm_s))); // R2
  AST_XP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) xp_run <= 16'(XP_W)); // R6
  AST_XN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) xn_run <= 16'(XN_W)); // R3
endmodule

bind srt_trigger_gen srt_trigger_chk #(.XN_W(XN_W_CYC), .XP_W(XP_W_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sout(sout), .xn(xn), .xp(xp),
  .pwm_s(pwm_s), .duty_ok(duty_ok)
);

// File: tb/sim_srt_trigger_gen.sv
module sim_srt_trigger_gen;
  localparam int CW = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic       det = 1'b1;
  logic [3:0] adj = 4'd0;
  logic       sout, xn, xp;

  always #10 clk = ~clk;

  srt_trigger_gen #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .det_in(det), .dly_adj(adj),
    .sout(sout), .xn(xn), .xp(xp)
  );

  int cyc = 0;
  int vec = 0;
  int bad = 0;
  bit done = 0;
  int sout_f = 0, sout_r = 0, xn_r = 0, xn_f = 0, xp_r = 0, xp_f = 0;
  int sout_n = 0, xn_n = 0, xp_n = 0, ovl = 0;
  logic sq = 0, nq = 0, pq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Edge recorder: times are clock-edge numbers
  always @(posedge clk) begin
    #2;
    if (sout !== sq) begin if (sout) begin sout_r = cyc; sout_n++; end else sout_f = cyc; end
    if (xn !== nq)   begin if (xn) begin xn_r = cyc; xn_n++; end else xn_f = cyc; end
    if (xp !== pq)   begin if (xp) begin xp_r = cyc; xp_n++; end else xp_f = cyc; end
    if (xn && xp) ovl++;
    sq = sout; nq = xn; pq = xp;
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int r, f, d, s0, n0;
    tk(4);
    chk("R1 sout in reset", int'(sout), 0);
    chk("R1 xn in reset", int'(xn), 0);
    chk("R1 xp in reset", int'(xp), 0);
    rst_n = 1'b1;
    tk(5);

    // First period: no duty measurement yet, so no XP (R1)
    pwm = 1; r = cyc + 1; tk(200);
    chk("R1 xp inhibited before first measurement", xp_n, 0);
    chk("R2 sout rise", sout_r, r + 32);
    pwm = 0; tk(200);

    // Dead-time sweep (R3 R5 R6 R7 R8)
    for (int a = 0; a < 16; a++) begin
      adj = 4'(a);
      pwm = 1; r = cyc + 1; tk(200);
      chk("R2 sout rise", sout_r, r + 32);
      chk("R3 xn rise after pwm rise", xn_r, r + 7);
      chk("R3 xn width", xn_f, r + 37);
      chk("R6 R8 xp after sout rise", xp_r, mx(r + 34 + a, r + 38));
      chk("R6 xp width", xp_f - xp_r, 70);
      pwm = 0; f = cyc + 1; tk(60);
      chk("R3 xn rise after pwm fall", xn_r, f + 7);
      chk("R2 sout fall", sout_f, f + 12);
      chk("R5 xn before sout fall", int'(xn_r < sout_f), 1);
      det = 0; d = cyc + 1; tk(100);
      chk("R7 xp after det fall", xp_r, d + 7);
      chk("R6 xp width from det", xp_f, d + 77);
      det = 1; tk(140);
    end

    // DET arriving while XN busy (R8)
    adj = 4'd0;
    for (int k = 0; k < 3; k++) begin
      int off;
      off = (k == 0) ? 2 : ((k == 1) ? 25 : 40);
      pwm = 1; tk(200);
      pwm = 0; f = cyc + 1; tk(off);
      det = 0; d = cyc + 1; tk(100);
      chk("R8 det xp held by xn", xp_r, mx(d + 7, f + 38));
      det = 1; tk(100);
    end

    // XN rising cuts XP short (R9)
    pwm = 1; r = cyc + 1; tk(60);
    pwm = 0; f = cyc + 1; tk(100);
    chk("R9 xp start", xp_r, r + 38);
    chk("R9 xp cut at xn rise", xp_f, f + 7);
    chk("R9 xn rise", xn_r, f + 7);
    tk(300);

    // Short PWM pulse: filtered from SOUT, XN restarted (R2 R4)
    s0 = sout_n; n0 = xn_n;
    pwm = 1; r = cyc + 1; tk(10);
    pwm = 0; f = cyc + 1; tk(100);
    chk("R2 short pulse filtered", sout_n - s0, 0);
    chk("R4 xn restarted count", xn_n - n0, 2);
    chk("R4 first xn cut", xn_r, f + 7);
    chk("R4 restarted xn end", xn_f, f + 37);
    tk(290);

    // Duty sweep around 10 percent of a 400-cycle period (R10)
    for (int h = 36; h <= 44; h++) begin
      pwm = 1; tk(h);
      pwm = 0; tk(400 - h);
      s0 = xp_n; n0 = xn_n;
      pwm = 1; tk(150);
      chk("R10 xp gated by duty", xp_n - s0, (10 * h >= 400) ? 1 : 0);
      chk("R10 xn continues", xn_n - n0, 1);
      tk(50);
      pwm = 0; tk(200);
    end

    // Period counter overflow (R11)
    pwm = 1; tk(200);
    pwm = 0; tk(1500);
    s0 = xp_n;
    det = 0; tk(100);
    chk("R11 det ignored after overflow", xp_n - s0, 0);
    det = 1; tk(10);
    s0 = xp_n;
    pwm = 1; tk(150);
    chk("R11 overflowed period fails", xp_n - s0, 0);
    tk(50);
    pwm = 0; tk(200);
    s0 = xp_n;
    pwm = 1; tk(150);
    chk("R10 xp resumes", xp_n - s0, 1);
    tk(50);
    pwm = 0; tk(100);

    chk("R9 overlap cycles", ovl, 0);
    finish_run();
  end
endmodule